// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Core

This block is a cycle-level, synthesizable model of the parallel test function inside a x4 dynamic memory. It samples the active-low row strobe, column strobe and write enable on every clock. Each row-strobe cycle is sorted into one of four kinds: an ordinary access, a column-before-row refresh, a column-before-row refresh with write enable low, or a row-only refresh. A write-enabled refresh sets a test-mode flag. The flag then stays set through any number of ordinary accesses. Only a plain column-before-row refresh or a row-only refresh clears it.

In normal operation the block stores and returns one 4-bit word per row/column address from a small register array. In test mode the two lowest column bits are not used. A write copies the data word into the four columns that share the upper column bits. A read returns one compare flag per data bit: high when the four stored copies of that bit agree, low when they do not. The compare result appears one clock later than normal read data.

Top module: `dram_ptest`

## Requirements
- R1: After reset, `test_mode` and `dout_valid` are both 0.
- R2: `test_mode` goes to 1 on the clock edge after a row-strobe fall. The fall must be sampled with `cas_n` low and with `we_n` low both at that edge and at the edge before it, and `we_n` must still be low at the following edge.
- R3: If `we_n` rises at the edge after such a fall (hold missed), or was high at the edge before the fall (setup missed), the cycle counts as a plain column-before-row refresh and `test_mode` is 0 afterwards.
- R4: Once set, `test_mode` stays 1 through ordinary read and write accesses.
- R5: A column-before-row refresh with `we_n` high clears `test_mode`.
- R6: A row-strobe cycle that opens a row and closes it with no column-strobe fall (row-only refresh) clears `test_mode`.
- R7: In normal mode, the row address is latched at the row-strobe fall and the column address at each column-strobe fall. If `we_n` is low at the column-strobe fall, `din` is written; otherwise the addressed word is on `dout`, with `dout_valid` high, right after that same edge.
- R8: In test mode, a write stores `din` in all four columns whose address differs only in column bits 1 and 0.
- R9: In test mode, a read ignores column bits 1 and 0. `dout` bit b is 1 when bit b of the four words in the group is all ones or all zeros, and 0 otherwise.
- R10: A test-mode read shows `dout_valid` low after the column-strobe fall edge and high one edge later.
- R11: `dout_valid` and `dout` hold while `cas_n` stays low. `dout_valid` drops after the first edge at which `cas_n` is sampled high.
- R12: Several column accesses, reads and writes mixed, can be made within one open row (page mode), and each gives the result of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 3 | Multiplexed row/column address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data, or compare flags in test mode |
| dout_valid | output | 1 | `dout` holds a finished read |
| test_mode | output | 1 | Test-mode flag |

## Verification
The assertions assume that a column-strobe fall only counts as an access while a row opened with the column strobe high is still open, and that `cas_n` is high for at least one sample between two column accesses. The stimulus changes every strobe on the falling clock edge. It always puts one high sample of `cas_n` between accesses and closes each row with the column strobe high, so every edge is seen exactly once. The entry checks rely on `we_n` changing only one or more samples away from the row-strobe fall, except in the two sequences that deliberately break setup or hold.

// File: rtl/dram_ptest_pkg.sv
package dram_ptest_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_ROW,
    CYC_CBR,
    CYC_WCBR
  } cyc_kind_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_ptest_dec.sv
module dram_ptest_dec
  import dram_ptest_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic row_stb,
  output logic col_stb,
  output logic col_wr,
  output logic test_mode
);
  logic      ras_q, cas_q, we_q;
  cyc_kind_e cls_q, cls_d;
  logic      hold_q, hold_d;
  logic      seen_q, seen_d;
  logic      tm_q, tm_d;
  logic      ras_fall, ras_rise, cas_fall;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;

  assign row_stb   = ras_fall & cas_n;
  assign col_stb   = (cls_q == CYC_ROW) & ~ras_n & cas_fall;
  assign col_wr    = ~we_n;
  assign test_mode = tm_q;

  // cycle kind is fixed at the row-strobe fall; write-enable hold is checked one edge later
  always_comb begin
    cls_d  = cls_q;
    hold_d = 1'b0;
    seen_d = seen_q;
    tm_d   = tm_q;
    if (ras_fall) begin
      if (cas_n) begin
        cls_d  = CYC_ROW;
        seen_d = 1'b0;
      end else if (!we_n && !we_q) begin
        cls_d  = CYC_WCBR;
        hold_d = 1'b1;
      end else begin
        cls_d = CYC_CBR;
        tm_d  = 1'b0;
      end
    end else begin
      if (hold_q) begin
        if (we_n) begin
          cls_d = CYC_CBR;
          tm_d  = 1'b0;
        end else begin
          tm_d = 1'b1;
        end
      end
      if (col_stb) seen_d = 1'b1;
      if (ras_rise) begin
        if (cls_q == CYC_ROW && !seen_q) tm_d = 1'b0;
        cls_d = CYC_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      cls_q  <= CYC_IDLE;
      hold_q <= 1'b0;
      seen_q <= 1'b0;
      tm_q   <= 1'b0;
    end else begin
      ras_q  <= ras_n;
      cas_q  <= cas_n;
      we_q   <= we_n;
      cls_q  <= cls_d;
      hold_q <= hold_d;
      seen_q <= seen_d;
      tm_q   <= tm_d;
    end
  end

  AST_ENTRY_ON_WCBR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tm_q) |-> (!$past(we_n) && !$past(we_n, 2) && !$past(cas_n, 2) && !$past(ras_n, 2))); // R2
  AST_TM_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    col_stb |=> $stable(tm_q)); // R4
  AST_CBR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && !ras_n && !cas_n && we_n) |=> !tm_q); // R5
endmodule

// File: rtl/dram_ptest_array.sv
module dram_ptest_array #(
  parameter int RAW = 3,
  parameter int CAW = 3,
  parameter int DQW = 4,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic [DQW-1:0] din,
  input  logic           row_stb,
  input  logic           col_stb,
  input  logic           col_wr,
  input  logic           tm,
  input  logic           cas_n,
  output logic [DQW-1:0] dout,
  output logic           dout_valid
);
  localparam int IW    = RAW + CAW;
  localparam int DEPTH = 1 << IW;
  localparam int GRP   = 4;
  localparam logic [CAW-1:0] LOWMASK = CAW'(GRP - 1);

  logic [RAW-1:0] row_q, row_d;
  logic [CAW-1:0] col;
  logic [DQW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] wen;
  logic [DQW-1:0] grp [GRP];
  logic [DQW-1:0] rd_word, cmp_now;
  logic           pend_q, pend_d;
  logic [DQW-1:0] cmp_q, cmp_d;
  logic [DQW-1:0] dout_q, dout_d;
  logic           vld_q, vld_d;

  assign col   = addr[CAW-1:0];
  assign row_d = row_stb ? addr[RAW-1:0] : row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  // word enables: one word in normal mode, a group of four in test mode
  for (genvar w = 0; w < DEPTH; w++) begin : g_wen
    localparam logic [IW-1:0] WI = IW'(w);
    assign wen[w] = col_stb & col_wr & (WI[IW-1:CAW] == row_q) &
                    (tm ? ((WI[CAW-1:0] | LOWMASK) == (col | LOWMASK))
                        : (WI[CAW-1:0] == col));
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < DEPTH; w++) begin
      if (wen[w]) mem[w] <= din;
    end
  end

  assign rd_word = mem[{row_q, col}];

  for (genvar k = 0; k < GRP; k++) begin : g_grp
    assign grp[k] = mem[{row_q, (col & ~LOWMASK) | CAW'(k)}];
  end

  assign cmp_now = (grp[0] & grp[1] & grp[2] & grp[3]) |
                   ~(grp[0] | grp[1] | grp[2] | grp[3]);

  always_comb begin
    pend_d = 1'b0;
    cmp_d  = cmp_q;
    dout_d = dout_q;
    vld_d  = vld_q;
    if (cas_n) begin
      vld_d = 1'b0;
    end else if (col_stb && !col_wr) begin
      if (tm) begin
        pend_d = 1'b1;
        cmp_d  = cmp_now;
        vld_d  = 1'b0;
      end else begin
        dout_d = rd_word;
        vld_d  = 1'b1;
      end
    end else if (pend_q) begin
      dout_d = cmp_q;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cmp_q  <= '0;
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      cmp_q  <= cmp_d;
      dout_q <= dout_d;
      vld_q  <= vld_d;
    end
  end

  assign dout       = dout_q;
  assign dout_valid = vld_q;

  AST_NORMAL_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && !col_wr && !tm) |=> dout_valid); // R7
  AST_TEST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && !col_wr && tm) |=> !dout_valid); // R10
  AST_TEST_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (col_stb && !col_wr && tm) ##1 !cas_n |=> dout_valid); // R10
  AST_DROP_ON_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |=> !dout_valid); // R11
  AST_HOLD_WHILE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !cas_n) |=> (dout_valid && $stable(dout))); // R11
endmodule

// File: rtl/dram_ptest.sv
module dram_ptest
  import dram_ptest_pkg::*;
#(
  parameter int RAW = 3,
  parameter int CAW = 3,
  parameter int DQW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [max2(RAW, CAW)-1:0]     addr,
  input  logic [DQW-1:0]                din,
  output logic [DQW-1:0]                dout,
  output logic                          dout_valid,
  output logic                          test_mode
);
  localparam int AW = max2(RAW, CAW);

  logic rst_meta, rst_s;
  logic row_stb, col_stb, col_wr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  dram_ptest_dec u_dec (
    .clk       (clk),
    .rst_n     (rst_s),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .row_stb   (row_stb),
    .col_stb   (col_stb),
    .col_wr    (col_wr),
    .test_mode (test_mode)
  );

  dram_ptest_array #(
    .RAW (RAW),
    .CAW (CAW),
    .DQW (DQW),
    .AW  (AW)
  ) u_arr (
    .clk        (clk),
    .rst_n      (rst_s),
    .addr       (addr),
    .din        (din),
    .row_stb    (row_stb),
    .col_stb    (col_stb),
    .col_wr     (col_wr),
    .tm         (test_mode),
    .cas_n      (cas_n),
    .dout       (dout),
    .dout_valid (dout_valid)
  );
endmodule

// File: tb/sim_dram_ptest.sv
module sim_dram_ptest;
  logic       clk;
  logic       rst_n;
  logic       ras_n, cas_n, we_n;
  logic [2:0] addr;
  logic [3:0] din;
  logic [3:0] dout;
  logic       dout_valid, test_mode;

  int n_tests;
  int n_fail;
  bit done;

  dram_ptest u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_valid(dout_valid),
    .test_mode(test_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [2:0] OP_WN = 3'd0, OP_RN = 3'd1, OP_TEN = 3'd2, OP_TEX = 3'd3,
                         OP_WT = 3'd4, OP_RT = 3'd5, OP_XR = 3'd6;
  localparam int NV = 19;
  // {op, row, col, data, expected}
  localparam logic [16:0] VEC [NV] = '{
    {OP_WN,  3'd1, 3'd0, 4'hA, 4'h0},
    {OP_WN,  3'd1, 3'd1, 4'hA, 4'h0},
    {OP_WN,  3'd1, 3'd2, 4'hA, 4'h0},
    {OP_WN,  3'd1, 3'd3, 4'h5, 4'h0},
    {OP_RN,  3'd1, 3'd3, 4'h0, 4'h5},
    {OP_RN,  3'd1, 3'd0, 4'h0, 4'hA},
    {OP_TEN, 3'd0, 3'd0, 4'h0, 4'h0},
    {OP_RT,  3'd1, 3'd2, 4'h0, 4'h0},
    {OP_WT,  3'd2, 3'd5, 4'h6, 4'h0},
    {OP_RT,  3'd2, 3'd4, 4'h0, 4'hF},
    {OP_RT,  3'd1, 3'd1, 4'h0, 4'h0},
    {OP_TEX, 3'd0, 3'd0, 4'h0, 4'h0},
    {OP_RN,  3'd2, 3'd7, 4'h0, 4'h6},
    {OP_RN,  3'd2, 3'd4, 4'h0, 4'h6},
    {OP_WN,  3'd2, 3'd6, 4'h7, 4'h0},
    {OP_TEN, 3'd0, 3'd0, 4'h0, 4'h0},
    {OP_RT,  3'd2, 3'd7, 4'h0, 4'hE},
    {OP_XR,  3'd0, 3'd0, 4'h0, 4'h0},
    {OP_RN,  3'd2, 3'd6, 4'h0, 4'h7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic open_row(input logic [2:0] row);
    @(negedge clk); addr = row; ras_n = 1'b0;
  endtask

  task automatic close_row();
    @(negedge clk); ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_col(input logic [2:0] col, input logic [3:0] d);
    @(negedge clk); addr = col; din = d; we_n = 1'b0; cas_n = 1'b0;
    @(negedge clk); cas_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd_col(input logic [2:0] col, input logic [3:0] exp,
                        input bit tmode, input string req);
    @(negedge clk); addr = col; we_n = 1'b1; cas_n = 1'b0;
    @(negedge clk);
    if (!tmode) begin
      chk({req, " valid"}, dout_valid, 1);
    end else begin
      chk("R10 valid low on first edge", dout_valid, 0);
      @(negedge clk);
      chk("R10 valid one edge later", dout_valid, 1);
    end
    chk(req, dout, exp);
    @(negedge clk);
    chk("R11 hold valid", dout_valid, 1);
    chk("R11 hold data", dout, exp);
    cas_n = 1'b1;
    @(negedge clk);
    chk("R11 drop valid", dout_valid, 0);
  endtask

  task automatic enter_tm(input bit hold_ok);
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); cas_n = 1'b0;
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk); we_n = hold_ok ? 1'b0 : 1'b1;
    @(negedge clk); ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cbr(input bit late_we);
    @(negedge clk); cas_n = 1'b0;
    @(negedge clk); ras_n = 1'b0; we_n = late_we ? 1'b0 : 1'b1;
    @(negedge clk);
    @(negedge clk); ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ras_only(input logic [2:0] row);
    open_row(row);
    @(negedge clk);
    close_row();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 test_mode", test_mode, 0);
    chk("R1 dout_valid", dout_valid, 0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op, row, col;
      logic [3:0] dat, exp;
      {op, row, col, dat, exp} = VEC[i];
      case (op)
        OP_WN: begin open_row(row); wr_col(col, dat); close_row(); end
        OP_RN: begin open_row(row); rd_col(col, exp, 1'b0, "R7 normal read"); close_row(); end
        OP_TEN: begin enter_tm(1'b1); chk("R2 entry", test_mode, 1); end
        OP_TEX: begin cbr(1'b0); chk("R5 plain refresh exit", test_mode, 0); end
        OP_WT: begin open_row(row); wr_col(col, dat); close_row(); chk("R8 stays in test", test_mode, 1); end
        OP_RT: begin
          open_row(row); rd_col(col, exp, 1'b1, "R9 compare read"); close_row();
          chk("R4 latched", test_mode, 1);
        end
        OP_XR: begin ras_only(row); chk("R6 row-only exit", test_mode, 0); end
        default: ;
      endcase
    end

    // R12: page mode, mixed accesses in one open row
    open_row(3'd1);
    rd_col(3'd3, 4'h5, 1'b0, "R12 page read 1");
    rd_col(3'd0, 4'hA, 1'b0, "R12 page read 2");
    wr_col(3'd1, 4'hB);
    rd_col(3'd1, 4'hB, 1'b0, "R12 page read after write");
    close_row();

    // R3: hold and setup violations
    enter_tm(1'b0);
    chk("R3 hold missed from idle", test_mode, 0);
    enter_tm(1'b1);
    chk("R3 precondition entry", test_mode, 1);
    enter_tm(1'b0);
    chk("R3 hold missed clears", test_mode, 0);
    enter_tm(1'b1);
    chk("R3 re-entry", test_mode, 1);
    cbr(1'b1);
    chk("R3 setup missed clears", test_mode, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule